// File: doc/BRIEF.md
# SD Command Engine with CE-ATA Completion

This block drives the command line of an SD/SDIO host. On a start request it captures a command index, a 32-bit argument and a set of flags, builds a 48-bit command frame with its CRC7, and shifts it out one bit per clock, MSB first. If a response is expected, it releases the line, waits a bounded time for the card's start bit, collects a 48-bit short response and checks its CRC. It then reports the response index and argument.

Two follow-up behaviours hang off the response. A command flagged as a suspend request raises a one-cycle acknowledge toward the data path when the card's reply is well formed and echoes the command index. A command flagged as an ATA command (CMD61) with its no-interrupt flag set runs the CE-ATA completion handshake. With completion enabled, the engine waits for the device to pull the line low. With completion disabled, it pauses eight clocks and then sends the five-bit completion-disable pattern. It does this by preloading its shift register and starting its bit counter at 43, so that only the frame tail is sent.

Top module: `sdcmd_engine`

## Requirements
- R1: In the cycle after an accepted `cmd_start`, `cmd_oe` rises and `cmd_out` carries the 48 frame bits MSB first, one per clock: 0, 1, index[5:0], argument[31:0], CRC7 (polynomial x^7+x^3+1, zero seed, over the first 40 bits), 1. Whenever `cmd_oe` is low, `cmd_out` is 1.
- R2: `busy` is low after reset and whenever the engine is idle. A command without `want_rsp` returns to idle in the cycle after its last bit.
- R3: With `want_rsp` set, the engine listens for a low start bit on `cmd_in` during the 64 cycles that follow the end bit. After the 48 response bits it pulses `rsp_valid` for one cycle, with `rsp_index` = response bits 2..7 and `rsp_arg` = bits 8..39.
- R4: If no start bit appears in those 64 cycles, `flag_timeout` is set and the engine goes idle without `rsp_valid`.
- R5: `flag_crc_fail` is set with `rsp_valid` when the response CRC7 over its first 40 bits mismatches bits 40..46, the transmission bit (bit 1) is not 0, or the end bit is not 1.
- R6: For a command flagged `is_suspend`, `susp_ack` pulses in the same cycle as `rsp_valid` if and only if the response passed the R5 check and its index equals the command index.
- R7: When `ata_cmd` is clear, `cpl_enable` and `no_intr` have no effect: the engine goes idle after the response.
- R8: With `ata_cmd` and `no_intr` set and `cpl_enable` clear, the engine stays busy with the line released for the 8 cycles starting with the `rsp_valid` cycle. It then drives 0,0,0,0,1 and goes idle without awaiting a response.
- R9: With `ata_cmd`, `no_intr` and `cpl_enable` all set, the engine stays busy with the line released after the response until `cmd_in` is sampled low. It then goes idle and sets `ata_done`.
- R10: `irq` equals `ata_done` AND `cpl_irq_en`.
- R11: `cmd_start` is ignored while busy. An accepted `cmd_start` clears `flag_timeout`, `flag_crc_fail` and `ata_done`.
- R12: With `ata_cmd` set but `no_intr` clear, no completion handshake follows the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start request, accepted when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| want_rsp | input | 1 | A short response is expected |
| is_suspend | input | 1 | Command is a suspend request |
| cpl_enable | input | 1 | CE-ATA completion enable flag |
| no_intr | input | 1 | CE-ATA no-interrupt flag |
| ata_cmd | input | 1 | Command is the ATA command |
| cpl_irq_en | input | 1 | Enables `irq` on CE-ATA completion |
| cmd_in | input | 1 | Sampled CMD line |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Engine not idle |
| rsp_valid | output | 1 | One-cycle response-complete pulse |
| rsp_index | output | 6 | Received response index |
| rsp_arg | output | 32 | Received response argument |
| susp_ack | output | 1 | Suspend accepted, to the data path |
| flag_timeout | output | 1 | Response timeout status |
| flag_crc_fail | output | 1 | Response check failure status |
| ata_done | output | 1 | CE-ATA completion status |
| irq | output | 1 | CE-ATA completion interrupt |

## Verification
The suspend acknowledge and the entry into the completion-disable pause can land on the same clock, when one command carries both the suspend flag and the ATA flags. The bench issues such a command with a well-formed, index-matching reply. Its reference model expects `susp_ack` and `rsp_valid` together in the first pause cycle, the line released for eight cycles and then the five-bit pattern. The same pairing with a corrupted CRC must show the pause and pattern but no acknowledge.

// File: rtl/sdcmd_pkg.sv
// Shared widths, state encoding and frame CRC for the SD command engine.
// Assumes a 48-bit short frame: 2 header bits, 6-bit index, 32-bit argument,
// 7-bit CRC and an end bit.
package sdcmd_pkg;

    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CRC_W   = 7;
    localparam int HDR_W   = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = HDR_W + CRC_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT_RSP,
        ST_RECV,
        ST_PEND,
        ST_WAIT_CPL
    } cmd_state_e;

    // CRC7 (x^7 + x^3 + 1, zero seed) over the frame header, MSB first.
    function automatic logic [CRC_W-1:0] crc7_hdr(input logic [HDR_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            fb = d[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tick_timer.sv
// Cycle counter that flags the last cycle of a LIMIT-cycle window.
// Assumes LIMIT >= 2; clr has priority over en.
module sdcmd_tick_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [W-1:0] cnt;

    // Count enabled cycles, restarting whenever cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end

    assign last = en && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/sdcmd_crc7_acc.sv
// Serial CRC7 accumulator for received bits, MSB first.
// Assumes the caller clears it before a frame and enables it per data bit.
module sdcmd_crc7_acc
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    logic fb;

    assign fb = bit_in ^ crc[CRC_W-1];

    // Fold one incoming bit into the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
endmodule

// File: rtl/sdcmd_engine.sv
// Command-path engine: serializes commands, receives short responses,
// acknowledges suspends and runs the CE-ATA completion handshake.
// Assumes one bit per clk and cmd_in already synchronous to clk.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int RSP_WAIT   = 64,
    parameter int PEND_GAP   = 8,
    parameter int DIS_PRESET = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             want_rsp,
    input  logic             is_suspend,
    input  logic             cpl_enable,
    input  logic             no_intr,
    input  logic             ata_cmd,
    input  logic             cpl_irq_en,
    input  logic             cmd_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             busy,
    output logic             rsp_valid,
    output logic [IDX_W-1:0] rsp_index,
    output logic [ARG_W-1:0] rsp_arg,
    output logic             susp_ack,
    output logic             flag_timeout,
    output logic             flag_crc_fail,
    output logic             ata_done,
    output logic             irq
);
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int RX_W     = FRAME_W - 1;
    localparam int DIS_LEN  = FRAME_W - DIS_PRESET;
    localparam int IDX_HI   = RX_W - 2;
    localparam int IDX_LO   = IDX_HI - IDX_W + 1;
    localparam int ARG_HI   = IDX_LO - 1;
    localparam int ARG_LO   = ARG_HI - ARG_W + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(HDR_W);
    localparam logic [FRAME_W-1:0] DIS_FRAME =
        {{(DIS_LEN - 1){1'b0}}, 1'b1, {DIS_PRESET{1'b0}}};

    cmd_state_e         state;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bitcnt;
    logic [RX_W-2:0]    rx_sh;
    logic [RX_W-1:0]    rx_full;
    logic [IDX_W-1:0]   l_idx;
    logic               l_rsp, l_susp, l_cplen, l_noint, l_ata;
    logic               in_dis;
    logic               rsp_last, pend_last;
    logic [CRC_W-1:0]   rx_crc;
    logic               rx_ok;
    logic [FRAME_W-1:0] tx_frame;

    // Build the outgoing frame with its CRC from the request inputs.
    always_comb begin
        tx_frame = {1'b0, 1'b1, cmd_index, cmd_arg,
                    crc7_hdr({2'b01, cmd_index, cmd_arg}), 1'b1};
    end

    // Received bits 1..47, the newest taken straight from the line.
    assign rx_full = {rx_sh, cmd_in};

    // Response is well formed: CRC, transmission bit and end bit agree.
    assign rx_ok = (rx_crc == rx_full[CRC_W:1]) && rx_full[0] && !rx_full[RX_W-1];

    sdcmd_tick_timer #(.LIMIT(RSP_WAIT)) u_rsp_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != ST_WAIT_RSP),
        .en   (state == ST_WAIT_RSP),
        .last (rsp_last)
    );

    sdcmd_tick_timer #(.LIMIT(PEND_GAP)) u_pend_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != ST_PEND),
        .en   (state == ST_PEND),
        .last (pend_last)
    );

    sdcmd_crc7_acc u_rx_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_WAIT_RSP),
        .en    ((state == ST_RECV) && (bitcnt < CRC_END)),
        .bit_in(cmd_in),
        .crc   (rx_crc)
    );

    // Line drive and status views of the current state.
    assign cmd_oe  = (state == ST_SEND);
    assign cmd_out = cmd_oe ? shreg[FRAME_W-1] : 1'b1;
    assign busy    = (state != ST_IDLE);
    assign irq     = ata_done && cpl_irq_en;

    // Sequence the command, response and completion phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            shreg         <= '0;
            bitcnt        <= '0;
            rx_sh         <= '0;
            l_idx         <= '0;
            l_rsp         <= 1'b0;
            l_susp        <= 1'b0;
            l_cplen       <= 1'b0;
            l_noint       <= 1'b0;
            l_ata         <= 1'b0;
            in_dis        <= 1'b0;
            rsp_valid     <= 1'b0;
            susp_ack      <= 1'b0;
            rsp_index     <= '0;
            rsp_arg       <= '0;
            flag_timeout  <= 1'b0;
            flag_crc_fail <= 1'b0;
            ata_done      <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            susp_ack  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        shreg         <= tx_frame;
                        bitcnt        <= '0;
                        l_idx         <= cmd_index;
                        l_rsp         <= want_rsp;
                        l_susp        <= is_suspend;
                        l_cplen       <= cpl_enable;
                        l_noint       <= no_intr;
                        l_ata         <= ata_cmd;
                        in_dis        <= 1'b0;
                        flag_timeout  <= 1'b0;
                        flag_crc_fail <= 1'b0;
                        ata_done      <= 1'b0;
                        state         <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    shreg  <= {shreg[FRAME_W-2:0], 1'b1};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT)
                        state <= (l_rsp && !in_dis) ? ST_WAIT_RSP : ST_IDLE;
                end
                ST_WAIT_RSP: begin
                    if (!cmd_in) begin
                        bitcnt <= CNT_W'(1);
                        state  <= ST_RECV;
                    end else if (rsp_last) begin
                        flag_timeout <= 1'b1;
                        state        <= ST_IDLE;
                    end
                end
                ST_RECV: begin
                    rx_sh <= rx_full[RX_W-2:0];
                    if (bitcnt == LAST_BIT) begin
                        rsp_valid <= 1'b1;
                        rsp_index <= rx_full[IDX_HI:IDX_LO];
                        rsp_arg   <= rx_full[ARG_HI:ARG_LO];
                        if (!rx_ok) flag_crc_fail <= 1'b1;
                        susp_ack  <= l_susp && rx_ok && (rx_full[IDX_HI:IDX_LO] == l_idx);
                        if (l_ata && l_noint && l_cplen) begin
                            state <= ST_WAIT_CPL;
                        end else if (l_ata && l_noint) begin
                            shreg  <= DIS_FRAME;
                            bitcnt <= CNT_W'(DIS_PRESET);
                            in_dis <= 1'b1;
                            state  <= ST_PEND;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_PEND: begin
                    if (pend_last) state <= ST_SEND;
                end
                ST_WAIT_CPL: begin
                    if (!cmd_in) begin
                        ata_done <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_engine_chk.sv
// Property checker for sdcmd_engine, attached by bind below.
// Assumes the port names of the engine.
module sdcmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic cmd_out,
    input logic cmd_oe,
    input logic busy,
    input logic rsp_valid,
    input logic susp_ack,
    input logic flag_timeout,
    input logic flag_crc_fail,
    input logic ata_done,
    input logic irq
);
    p_drive_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy);

    p_release_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_timeout_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_timeout) |-> (!busy && !rsp_valid));

    p_crc_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_crc_fail) |-> rsp_valid);

    p_susp_with_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ack |-> rsp_valid);

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ack |=> !susp_ack);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_done) |-> !busy);

    p_irq_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ata_done);

    p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> (busy && !flag_timeout && !flag_crc_fail && !ata_done));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (.*);

// File: tb/sdcmd_engine_bench.sv
// Bench with a behavioural per-cycle reference: each command is expanded
// into a queue of expected slots that is compared on every clock.
module sdcmd_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        want_rsp = 1'b0, is_suspend = 1'b0, cpl_enable = 1'b0;
    logic        no_intr = 1'b0, ata_cmd = 1'b0, cpl_irq_en = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, busy, rsp_valid, susp_ack;
    logic [5:0]  rsp_index;
    logic [31:0] rsp_arg;
    logic        flag_timeout, flag_crc_fail, ata_done, irq;

    sdcmd_engine u_sdcmd_engine (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic oe, out, busy, rv, sa, tmo, crc, done, cin;
        logic [5:0]  ridx;
        logic [31:0] rarg;
    } slot_t;

    slot_t exp_q[$];
    slot_t hold;
    int    n_chk = 0, n_fail = 0;
    bit    mon_on = 0, finished = 0;
    bit    m_tmo = 0, m_crc = 0, m_done = 0;
    string scen = "reset";

    function automatic logic [6:0] ref_crc7(input logic [39:0] d);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic top;
            top = r[6] ^ d[i];
            r = {r[5:0], 1'b0};
            if (top) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    task automatic push_slot(input logic oe, out, bsy, rv, sa, cin,
                             input logic [5:0] ri, input logic [31:0] ra);
        slot_t s;
        s.oe = oe; s.out = out; s.busy = bsy; s.rv = rv; s.sa = sa; s.cin = cin;
        s.tmo = m_tmo; s.crc = m_crc; s.done = m_done; s.ridx = ri; s.rarg = ra;
        exp_q.push_back(s);
    endtask

    task automatic chk(input string tag, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s [%s] got %0h expected %0h", scen, tag, got, exp);
        end
    endtask

    // Per-clock comparison against the expected slot, then line stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (mon_on) begin
                slot_t r;
                if (exp_q.size() > 0) begin
                    r = exp_q.pop_front();
                    hold = r;
                end else begin
                    r = hold;
                    r.oe = 0; r.out = 1; r.busy = 0; r.rv = 0; r.sa = 0; r.cin = 1;
                end
                chk("R1 cmd_oe", cmd_oe, r.oe);
                chk("R1 cmd_out", cmd_out, r.out);
                chk("R2 busy", busy, r.busy);
                chk("R3 rsp_valid", rsp_valid, r.rv);
                chk("R4 flag_timeout", flag_timeout, r.tmo);
                chk("R5 flag_crc_fail", flag_crc_fail, r.crc);
                chk("R6 susp_ack", susp_ack, r.sa);
                chk("R9 ata_done", ata_done, r.done);
                chk("R10 irq", irq, r.done & cpl_irq_en);
                if (r.rv) begin
                    chk("R3 rsp_index", rsp_index, r.ridx);
                    chk("R3 rsp_arg", rsp_arg, r.rarg);
                end
                cmd_in = r.cin;
            end
        end
    end

    // rdly < 0: no reply. cdly: cycles before the device signals completion.
    task automatic run_cmd(input string s, input logic [5:0] idx, input logic [31:0] arg,
                           input bit rsp, susp, cplen, noint, ata, irqen,
                           input int rdly, input logic [5:0] ridx, input logic [31:0] rarg,
                           input bit bad, input int cdly, input bit poke);
        logic [47:0] fr, rf;
        bit ok, ack;
        @(negedge clk);
        scen = s;
        cmd_index = idx; cmd_arg = arg; want_rsp = rsp; is_suspend = susp;
        cpl_enable = cplen; no_intr = noint; ata_cmd = ata; cpl_irq_en = irqen;
        m_tmo = 0; m_crc = 0; m_done = 0;
        fr = {1'b0, 1'b1, idx, arg, ref_crc7({2'b01, idx, arg}), 1'b1};
        for (int j = 0; j < 48; j++) push_slot(1, fr[47-j], 1, 0, 0, 1, '0, '0);
        if (rsp && rdly < 0) begin
            for (int w = 0; w < 64; w++) push_slot(0, 1, 1, 0, 0, 1, '0, '0);
            m_tmo = 1;
            push_slot(0, 1, 0, 0, 0, 1, '0, '0);
        end else if (rsp) begin
            rf = {1'b0, 1'b0, ridx, rarg,
                  ref_crc7({2'b00, ridx, rarg}) ^ (bad ? 7'h01 : 7'h00), 1'b1};
            ok  = !bad;
            ack = susp && ok && (ridx == idx);
            for (int w = 0; w < rdly; w++) push_slot(0, 1, 1, 0, 0, 1, '0, '0);
            push_slot(0, 1, 1, 0, 0, rf[47], '0, '0);
            for (int m = 1; m < 48; m++) push_slot(0, 1, 1, 0, 0, rf[47-m], '0, '0);
            m_crc = !ok;
            if (ata && noint && !cplen) begin
                // R8: eight released cycles, then the 0,0,0,0,1 pattern
                for (int p = 0; p < 8; p++)
                    push_slot(0, 1, 1, p == 0, (p == 0) && ack, 1, ridx, rarg);
                for (int b = 0; b < 5; b++) push_slot(1, b == 4, 1, 0, 0, 1, '0, '0);
            end else if (ata && noint && cplen) begin
                // R9: busy until the device pulls the line low
                for (int k = 0; k <= cdly; k++)
                    push_slot(0, 1, 1, k == 0, (k == 0) && ack, k == cdly ? 1'b0 : 1'b1,
                              ridx, rarg);
                m_done = 1;
                push_slot(0, 1, 0, 0, 0, 1, '0, '0);
            end else begin
                push_slot(0, 1, 0, 1, ack, 1, ridx, rarg);
            end
        end
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        if (poke) begin
            // R11: a second request while busy must leave the expected slots intact
            repeat (10) @(negedge clk);
            cmd_index = 6'h05; cmd_arg = 32'h0; want_rsp = 0; ata_cmd = 0;
            cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog [R2 busy] got hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hold = '{oe: 0, out: 1, busy: 0, rv: 0, sa: 0, tmo: 0, crc: 0, done: 0,
                 cin: 1, ridx: '0, rarg: '0};
        #(CLK_PERIOD / 4);
        chk("R2 reset busy", busy, 0);
        chk("R1 reset line", cmd_out, 1);
        mon_on = 1;
        repeat (3) @(negedge clk);

        run_cmd("R1 R2 no response", 6'h00, 32'h0000_0000, 0,0,0,0,0,0, 0, '0,'0, 0, 0, 0);
        run_cmd("R1 R2 no response ones", 6'h3F, 32'hFFFF_FFFF, 0,0,0,0,0,0, 0, '0,'0, 0, 0, 0);
        run_cmd("R3 reply at once", 6'h11, 32'hDEAD_BEEF, 1,0,0,0,0,0, 0, 6'h11, 32'h1234_5678, 0, 0, 0);
        run_cmd("R3 reply at last slot", 6'h07, 32'hA5A5_0F0F, 1,0,0,0,0,0, 63, 6'h07, 32'h8000_0001, 0, 0, 0);
        run_cmd("R4 timeout", 6'h02, 32'h0000_00FF, 1,0,0,0,0,0, -1, '0,'0, 0, 0, 0);
        run_cmd("R11 flags cleared", 6'h09, 32'h0BAD_F00D, 1,0,0,0,0,0, 4, 6'h09, 32'h0, 0, 0, 1);
        run_cmd("R5 R6 bad crc suspend", 6'h34, 32'h0000_0001, 1,1,0,0,0,0, 2, 6'h34, 32'h55AA_55AA, 1, 0, 0);
        run_cmd("R6 suspend accepted", 6'h34, 32'h0000_0002, 1,1,0,0,0,0, 9, 6'h34, 32'h0000_0000, 0, 0, 0);
        run_cmd("R6 suspend index mismatch", 6'h34, 32'h0000_0003, 1,1,0,0,0,0, 1, 6'h35, 32'h0000_0000, 0, 0, 0);
        run_cmd("R8 completion-disable", 6'h3D, 32'h0000_0100, 1,0,0,1,1,0, 5, 6'h3D, 32'hCAFE_0001, 0, 0, 0);
        run_cmd("R6 R8 suspend with disable", 6'h3D, 32'h0000_0200, 1,1,0,1,1,0, 3, 6'h3D, 32'h0, 0, 0, 0);
        run_cmd("R5 R8 bad crc with disable", 6'h3D, 32'h0000_0300, 1,1,0,1,1,0, 3, 6'h3D, 32'h0, 1, 0, 0);
        run_cmd("R9 R10 wait completion irq", 6'h3D, 32'h0000_0400, 1,0,1,1,1,1, 6, 6'h3D, 32'h7, 0, 20, 0);
        run_cmd("R9 R10 completion no irq", 6'h3D, 32'h0000_0500, 1,0,1,1,1,0, 0, 6'h3D, 32'h7, 0, 0, 0);
        run_cmd("R7 flags without ata, disable", 6'h3D, 32'h0000_0600, 1,0,0,1,0,0, 2, 6'h3D, 32'h1, 0, 0, 0);
        run_cmd("R7 flags without ata, enable", 6'h3D, 32'h0000_0700, 1,0,1,1,0,1, 2, 6'h3D, 32'h2, 0, 0, 0);
        run_cmd("R12 ata without no_intr", 6'h3D, 32'h0000_0800, 1,0,1,0,1,1, 2, 6'h3D, 32'h3, 0, 0, 0);
        run_cmd("R11 flags cleared after done", 6'h01, 32'h0, 0,0,0,0,0,1, 0, '0,'0, 0, 0, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule